// File: doc/BRIEF.md
# Program/Erase Status Flag Generator

This block sits between a nonvolatile memory's command decoder and its read data path. When the decoder has collected a complete program or erase command, it pulses a start input and names the operation. The block then holds a busy phase of a fixed number of clock cycles. During that phase it replaces the read data with two completion indicators, so that a host polling the memory can tell when the write has finished.

The first indicator is bit 7. For a program it is the inverse of the byte being written, and for an erase it is zero. The second indicator is bit 6, which changes value on every read strobe while the operation runs. A short settling phase follows the busy phase. In it, bit 7 already carries true array data, bit 6 stops changing, and the low bits are not yet valid. After that the block passes array data through unchanged. A busy output lets the decoder lock out further commands.

Top module: `status_flag_gen`

## Requirements
- R1: After reset `busy_o` is 0 and `rd_data_o` equals `array_data_i`.
- R2: The block accepts a start whose `op_i` is 00 (byte program), 01 (sector erase) or 10 (chip erase). `busy_o` rises on the cycle after the accepting edge and stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles respectively.
- R3: During a program busy phase, `rd_data_o[7]` is the complement of bit 7 of `prog_data_i` as captured on the accepting edge. Later changes of `prog_data_i` have no effect.
- R4: During an erase busy phase, `rd_data_o[7]` is 0.
- R5: In the busy phase, `rd_data_o[6]` is 1 up to and including the first read strobe. It inverts after each clock edge that has `rd_stb_i` high, and it holds on edges without a strobe.
- R6: `rd_data_o[5:0]` is 0 throughout the busy and settling phases.
- R7: The busy phase is followed by SETTLE_CYC settling cycles. In them `busy_o` is 0, `rd_data_o[7]` equals `array_data_i[7]`, and `rd_data_o[6]` keeps its last busy value whatever the read strobes do.
- R8: Once settling ends, `rd_data_o` equals `array_data_i`.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The remaining duration, the operation and the captured byte are all unchanged.
- R10: A start pulse with `op_i` = 11 is ignored. `busy_o` stays 0 and read data stays on the array path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse from the command decoder |
| op_i | input | 2 | Operation: 00 program, 01 sector erase, 10 chip erase, 11 none |
| prog_data_i | input | 8 | Byte being programmed, captured on start |
| rd_stb_i | input | 1 | Read strobe, one per host read access |
| array_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Read data returned to the host |
| busy_o | output | 1 | High while the internal operation runs |

## Verification
The hardest conditions to reach from the ports are a second start pulse in the middle of a busy phase and read strobes that arrive in the last busy cycle or during settling. Both rely on exact cycle counts. The bench holds a small set of durations and drives every operation over several data bytes and several strobe spacings. On selected runs it injects a conflicting start one cycle into the busy phase, and it toggles the strobe throughout settling. It then checks that the duration, bit 7 and the frozen bit 6 are all unaffected.

// File: rtl/flag_pkg.sv
package flag_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_NONE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_BUSY   = 2'b01,
        PH_SETTLE = 2'b10
    } phase_e;

endpackage

// File: rtl/flag_timer.sv
module flag_timer
    import flag_pkg::*;
#(
    parameter int PROG_CYC   = 20,
    parameter int SECT_CYC   = 50,
    parameter int CHIP_CYC   = 90,
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] op_i,
    output phase_e     phase_o,
    output logic [1:0] op_o,
    output logic       load_o
);

    localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_CD = (CHIP_CYC > SETTLE_CYC) ? CHIP_CYC : SETTLE_CYC;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);

    localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] SECT_LD = CW'(SECT_CYC - 1);
    localparam logic [CW-1:0] CHIP_LD = CW'(CHIP_CYC - 1);
    localparam logic [CW-1:0] SET_LD  = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        phase_e          phase;
        logic [1:0]      op;
        logic [CW-1:0]   cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic accept;

    assign accept = start_i && (st_q.phase != PH_BUSY) && (op_i != OP_NONE);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_BUSY: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_SETTLE;
                    st_d.cnt   = SET_LD;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_SETTLE: begin
                if (st_q.cnt == '0) st_d.phase = PH_IDLE;
                else                st_d.cnt   = st_q.cnt - 1'b1;
            end
            default: ;
        endcase
        if (accept) begin
            st_d.phase = PH_BUSY;
            st_d.op    = op_i;
            case (op_i)
                OP_PROG: st_d.cnt = PROG_LD;
                OP_SECT: st_d.cnt = SECT_LD;
                default: st_d.cnt = CHIP_LD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, op: OP_PROG, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign op_o    = st_q.op;
    assign load_o  = accept;

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BUSY && st_q.cnt != '0) |=> st_q.phase == PH_BUSY);

    // R7
    busy_to_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BUSY && st_q.cnt == '0) |=> st_q.phase == PH_SETTLE);

    // R9
    op_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_BUSY |=> st_q.op == $past(st_q.op));

    // R10
    none_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && op_i == OP_NONE) |=> st_q.phase == PH_IDLE);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < MAXC);

endmodule

// File: rtl/flag_toggle.sv
module flag_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic busy_i,
    input  logic rd_stb_i,
    output logic tog_o
);

    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (load_i)                  tog_d = 1'b1;
        else if (busy_i && rd_stb_i) tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog_o = tog_q;

    // R5
    first_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> tog_q);

    // R5
    flip_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_stb_i && !load_i) |=> tog_q != $past(tog_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !load_i) |=> $stable(tog_q));

endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
    import flag_pkg::*;
#(
    parameter int PROG_CYC   = 20,
    parameter int SECT_CYC   = 50,
    parameter int CHIP_CYC   = 90,
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] op_i,
    input  logic [7:0] prog_data_i,
    input  logic       rd_stb_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] rd_data_o,
    output logic       busy_o
);

    phase_e     phase;
    logic [1:0] op_cur;
    logic       load;
    logic       tog;
    logic [7:0] byte_d, byte_q;

    flag_timer #(
        .PROG_CYC   (PROG_CYC),
        .SECT_CYC   (SECT_CYC),
        .CHIP_CYC   (CHIP_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_i),
        .phase_o (phase),
        .op_o    (op_cur),
        .load_o  (load)
    );

    flag_toggle u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .busy_i   (busy_o),
        .rd_stb_i (rd_stb_i),
        .tog_o    (tog)
    );

    always_comb begin
        byte_d = byte_q;
        if (load) byte_d = prog_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_d;
    end

    always_comb begin
        case (phase)
            PH_BUSY:   rd_data_o = {(op_cur == OP_PROG) ? ~byte_q[7] : 1'b0, tog, 6'b0};
            PH_SETTLE: rd_data_o = {array_data_i[7], tog, 6'b0};
            default:   rd_data_o = array_data_i;
        endcase
    end

    assign busy_o = (phase == PH_BUSY);

    // R3
    byte_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(byte_q));

    // R9
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load);

    initial begin
        settle_len_chk: assert (SETTLE_CYC >= 1 && PROG_CYC >= 1 && SECT_CYC >= 1 && CHIP_CYC >= 1);
    end

endmodule

// File: tb/status_flag_gen_bench.sv
module status_flag_gen_bench;

    localparam int CLK_PER = 10;
    localparam int P_CYC   = 6;
    localparam int S_CYC   = 9;
    localparam int C_CYC   = 13;
    localparam int SET_CYC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] op_i = 2'b00;
    logic [7:0] prog_data_i = 8'h00;
    logic       rd_stb_i = 1'b0;
    logic [7:0] array_data_i = 8'h96;
    logic [7:0] rd_data_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    status_flag_gen #(
        .PROG_CYC   (P_CYC),
        .SECT_CYC   (S_CYC),
        .CHIP_CYC   (C_CYC),
        .SETTLE_CYC (SET_CYC)
    ) u_status_flag_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_i),
        .prog_data_i  (prog_data_i),
        .rd_stb_i     (rd_stb_i),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o),
        .busy_o       (busy_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [7:0] dat, input int gap, input bit poke);
        int         dur;
        logic [7:0] fin;
        logic       exp_tog;
        string      dreq;
        dur  = (op == 2'b00) ? P_CYC : (op == 2'b01) ? S_CYC : C_CYC;
        fin  = (op == 2'b00) ? dat : 8'hFF;
        dreq = poke ? "R9" : "R2";
        @(negedge clk);
        array_data_i = 8'h3C;
        start_i = 1'b1; op_i = op; prog_data_i = dat; rd_stb_i = 1'b0;
        #1 check("R2", {7'b0, busy_o}, 8'h00);
        @(negedge clk);
        start_i = 1'b0;
        prog_data_i = ~dat;
        exp_tog = 1'b1;
        for (int i = 0; i < dur; i++) begin
            if (poke && i == 1) begin
                start_i = 1'b1;
                op_i = (op == 2'b00) ? 2'b10 : 2'b00;
                prog_data_i = ~dat;
            end
            rd_stb_i = (i % gap == 0);
            #1;
            check(dreq, {7'b0, busy_o}, 8'h01);
            if (op == 2'b00) check(poke ? "R9" : "R3", {7'b0, rd_data_o[7]}, {7'b0, ~dat[7]});
            else             check("R4", {7'b0, rd_data_o[7]}, 8'h00);
            check("R5", {7'b0, rd_data_o[6]}, {7'b0, exp_tog});
            check("R6", {2'b0, rd_data_o[5:0]}, 8'h00);
            if (rd_stb_i) exp_tog = ~exp_tog;
            @(negedge clk);
            start_i = 1'b0;
            rd_stb_i = 1'b0;
        end
        array_data_i = fin;
        for (int j = 0; j < SET_CYC; j++) begin
            rd_stb_i = ((j % 2) == 0);
            #1;
            check(dreq, {7'b0, busy_o}, 8'h00);
            check("R7", {7'b0, rd_data_o[7]}, {7'b0, fin[7]});
            check("R7", {7'b0, rd_data_o[6]}, {7'b0, exp_tog});
            check("R6", {2'b0, rd_data_o[5:0]}, 8'h00);
            @(negedge clk);
        end
        rd_stb_i = 1'b0;
        #1 check("R8", rd_data_o, fin);
        array_data_i = ~fin;
        #1 check("R8", rd_data_o, ~fin);
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'h7F; pats[2] = 8'h80; pats[3] = 8'hA5;
        repeat (3) @(negedge clk);
        #1;
        check("R1", {7'b0, busy_o}, 8'h00);
        check("R1", rd_data_o, 8'h96);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1", rd_data_o, 8'h96);
        for (int o = 0; o < 3; o++)
            for (int d = 0; d < 4; d++)
                for (int g = 1; g <= 3; g++)
                    run(o[1:0], pats[d], g, (g == 2));
        @(negedge clk);
        array_data_i = 8'h5A;
        start_i = 1'b1; op_i = 2'b11; prog_data_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            rd_stb_i = 1'b1;
            #1;
            check("R10", {7'b0, busy_o}, 8'h00);
            check("R10", rd_data_o, 8'h5A);
            @(negedge clk);
        end
        rd_stb_i = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule